// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit Operation Unit

This combinational unit executes the second byte of a two-byte prefixed instruction in a small 8-bit processor core. It receives the sub-opcode, one operand byte and the four-bit condition flag nibble. From these it produces the result byte, a write-back enable and the new flag nibble. The sub-opcode selects one of four groups. The first group is eight shift, rotate and swap variants. The other three act on a single bit: test it, clear it or set it.

Operand fetch and result storage stay with the surrounding datapath. The unit only passes out the operand index carried in the sub-opcode, so the core can read the register or memory location and write it back.

The flag nibble is ordered zero (bit 3), subtract (bit 2), half-carry (bit 1) and carry (bit 0).

Top module: `prefix_bit_unit`

## Requirements
- R1: Sub-opcode bits 7..6 choose the group: 0 is shift/rotate, 1 is bit test, 2 is bit clear and 3 is bit set. Bits 5..3 give the variant or bit number. `src_idx` always equals bits 2..0.
- R2: Variant 0 rotates left circularly (bit 7 enters bit 0). Variant 1 rotates right circularly (bit 0 enters bit 7).
- R3: Variant 2 rotates left through carry, with incoming carry (flag bit 0) entering bit 0. Variant 3 rotates right through carry, with incoming carry entering bit 7.
- R4: Variant 4 shifts left and fills bit 0 with zero. Variant 5 shifts right and keeps bit 7. Variant 7 shifts right and fills bit 7 with zero.
- R5: Variant 6 exchanges the upper and lower nibbles and clears carry.
- R6: For every shift-group variant, zero is set exactly when the result is 0 and subtract and half-carry are cleared. For variants 0–5 and 7, carry takes the bit shifted out: bit 7 for left moves, bit 0 for right moves.
- R7: Bit test sets zero when the selected operand bit is 0. It clears subtract, sets half-carry and keeps carry. The result equals the operand.
- R8: Bit clear and bit set change only the selected bit of the operand and leave all four flags unchanged.
- R9: `wr_en` is high for the shift, clear and set groups and low for bit test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sub_op | input | 8 | Sub-opcode byte following the prefix |
| operand | input | 8 | Operand value fetched by the core |
| flags_in | input | 4 | Current flags {zero, subtract, half-carry, carry} |
| result | output | 8 | Computed byte to store |
| wr_en | output | 1 | Result must be written back to the operand location |
| flags_out | output | 4 | Updated flags, same ordering as flags_in |
| src_idx | output | 3 | Operand location index taken from the sub-opcode |

## Verification
All outputs are purely combinational, so every result is due in the same cycle that the inputs change, with no register in the path. The bench drives each stimulus just after a falling clock edge and samples the outputs one nanosecond later. It compares them there with values computed by its own model of the requirements, and the next input change comes only after that comparison. Directed corner cases cover all-zero and all-ones operands, carry in at both values, and bit numbers 0 and 7. A seeded random sweep covers the rest of the sub-opcode space.

// File: rtl/prefix_bit_unit.sv
module prefix_bit_unit (
  input  logic [7:0] sub_op,
  input  logic [7:0] operand,
  input  logic [3:0] flags_in,
  output logic [7:0] result,
  output logic       wr_en,
  output logic [3:0] flags_out,
  output logic [2:0] src_idx
);
  localparam logic [1:0] GRP_SHIFT = 2'd0;
  localparam logic [1:0] GRP_TEST  = 2'd1;
  localparam logic [1:0] GRP_CLR   = 2'd2;
  localparam logic [1:0] GRP_SET   = 2'd3;

  logic [1:0] grp;
  logic [2:0] sel;
  logic [7:0] mask;
  logic [7:0] sh_res;
  logic       sh_cy;
  logic       fill;
  logic       go_left;

  assign grp     = sub_op[7:6];
  assign sel     = sub_op[5:3];
  assign src_idx = sub_op[2:0];
  assign mask    = 8'd1 << sel;

  always_comb begin
    go_left = (sel == 3'd0) || (sel == 3'd2) || (sel == 3'd4);
    case (sel)
      3'd0:    fill = operand[7];
      3'd1:    fill = operand[0];
      3'd2,
      3'd3:    fill = flags_in[0];
      3'd5:    fill = operand[7];
      default: fill = 1'b0;
    endcase
    if (sel == 3'd6) begin
      sh_res = {operand[3:0], operand[7:4]};
      sh_cy  = 1'b0;
    end else if (go_left) begin
      sh_res = {operand[6:0], fill};
      sh_cy  = operand[7];
    end else begin
      sh_res = {fill, operand[7:1]};
      sh_cy  = operand[0];
    end
  end

  always_comb begin
    result    = operand;
    flags_out = flags_in;
    wr_en     = 1'b1;
    case (grp)
      GRP_SHIFT: begin
        result    = sh_res;
        flags_out = {sh_res == 8'h00, 1'b0, 1'b0, sh_cy};
      end
      GRP_TEST: begin
        wr_en     = 1'b0;
        flags_out = {(operand & mask) == 8'h00, 1'b0, 1'b1, flags_in[0]};
      end
      GRP_CLR: result = operand & ~mask;
      GRP_SET: result = operand | mask;
      default: result = operand;
    endcase
  end
endmodule

// File: rtl/prefix_bit_unit_chk.sv
module prefix_bit_unit_chk (
  input logic [7:0] sub_op,
  input logic [7:0] operand,
  input logic [3:0] flags_in,
  input logic [7:0] result,
  input logic       wr_en,
  input logic [3:0] flags_out,
  input logic [2:0] src_idx
);
  always_comb begin
    if (sub_op[7:6] == 2'd0)
      AST_SHIFT_FLAGS: assert (!flags_out[2] && !flags_out[1] && (flags_out[3] == (result == 8'h00))); // R6
    if (sub_op[7:3] == 5'b00110)
      AST_SWAP_NIBBLES: assert (result == {operand[3:0], operand[7:4]} && !flags_out[0]); // R5
    if (sub_op[7:6] == 2'd1)
      AST_TEST_KEEPS: assert (result == operand && flags_out[0] == flags_in[0] && flags_out[1] && !flags_out[2]); // R7
    if (sub_op[7] == 1'b1)
      AST_BITOP_FLAGS: assert (flags_out == flags_in && $countones(result ^ operand) <= 1); // R8
    AST_WRITE_ENABLE: assert (wr_en == (sub_op[7:6] != 2'd1)); // R9
    AST_INDEX_PASS: assert (src_idx == sub_op[2:0]); // R1
  end
endmodule

bind prefix_bit_unit prefix_bit_unit_chk chk (
  .sub_op(sub_op), .operand(operand), .flags_in(flags_in), .result(result),
  .wr_en(wr_en), .flags_out(flags_out), .src_idx(src_idx)
);

// File: tb/tb_prefix_bit_unit.sv
`timescale 1ns/1ps
module tb_prefix_bit_unit;
  logic clk = 1'b0;
  logic [7:0] sub_op;
  logic [7:0] operand;
  logic [3:0] flags_in;
  logic [7:0] result;
  logic       wr_en;
  logic [3:0] flags_out;
  logic [2:0] src_idx;
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prefix_bit_unit dut (
    .sub_op(sub_op), .operand(operand), .flags_in(flags_in), .result(result),
    .wr_en(wr_en), .flags_out(flags_out), .src_idx(src_idx)
  );

  function automatic logic [15:0] model(input logic [7:0] op, input logic [7:0] a, input logic [3:0] f);
    logic [7:0] r;
    logic c, z, w;
    logic [3:0] fo;
    r = a; c = f[0]; w = 1'b1; fo = f;
    case (op[7:6])
      2'd0: begin
        case (op[5:3])
          3'd0: begin r = {a[6:0], a[7]}; c = a[7]; end
          3'd1: begin r = {a[0], a[7:1]}; c = a[0]; end
          3'd2: begin r = {a[6:0], f[0]}; c = a[7]; end
          3'd3: begin r = {f[0], a[7:1]}; c = a[0]; end
          3'd4: begin r = {a[6:0], 1'b0}; c = a[7]; end
          3'd5: begin r = {a[7], a[7:1]}; c = a[0]; end
          3'd6: begin r = {a[3:0], a[7:4]}; c = 1'b0; end
          default: begin r = {1'b0, a[7:1]}; c = a[0]; end
        endcase
        fo = {r == 8'h00, 1'b0, 1'b0, c};
      end
      2'd1: begin
        z = (a[op[5:3]] == 1'b0);
        fo = {z, 1'b0, 1'b1, f[0]};
        w = 1'b0;
      end
      2'd2: r[op[5:3]] = 1'b0;
      default: r[op[5:3]] = 1'b1;
    endcase
    return {w, op[2:0], fo, r};
  endfunction

  function automatic string tag(input logic [7:0] op);
    if (op[7:6] == 2'd1) return "R7";
    if (op[7:6] != 2'd0) return "R8";
    case (op[5:3])
      3'd0, 3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd6: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic apply(input logic [7:0] op, input logic [7:0] a, input logic [3:0] f, input string extra);
    logic [15:0] exp;
    logic [15:0] got;
    @(negedge clk);
    sub_op = op; operand = a; flags_in = f;
    #1;
    exp = model(op, a, f);
    got = {wr_en, src_idx, flags_out, result};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s op=%02h a=%02h f=%h got=%04h exp=%04h", tag(op), extra, op, a, f, got, exp);
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    sub_op = 8'h00; operand = 8'h00; flags_in = 4'h0;
    @(negedge clk); #1;
    checks++;
    if (result !== 8'h00 || wr_en !== 1'b1 || flags_out !== 4'b1000) begin
      fails++;
      $display("FAIL R6 initial zero input got r=%02h w=%b f=%h exp r=00 w=1 f=8", result, wr_en, flags_out);
    end
    apply(8'h00, 8'h80, 4'h0, "R2 R6 circular left carry out");
    apply(8'h08, 8'h01, 4'h0, "R2 R6 circular right carry out");
    apply(8'h10, 8'h80, 4'h0, "R3 R6 through carry to zero");
    apply(8'h10, 8'h00, 4'h1, "R3 carry enters bit 0");
    apply(8'h18, 8'h00, 4'h1, "R3 carry enters bit 7");
    apply(8'h18, 8'h01, 4'h0, "R3 R6 right through carry zero");
    apply(8'h20, 8'hFF, 4'hF, "R4 shift left");
    apply(8'h28, 8'h81, 4'h0, "R4 arithmetic right keeps sign");
    apply(8'h38, 8'h81, 4'h0, "R4 logical right fills zero");
    apply(8'h30, 8'hA5, 4'h1, "R5 swap clears carry");
    apply(8'h30, 8'h00, 4'hF, "R5 R6 swap zero");
    apply(8'h7F, 8'h7F, 4'h0, "R7 test bit 7 clear");
    apply(8'h47, 8'h01, 4'hF, "R7 R9 test bit 0 set");
    apply(8'h87, 8'hFF, 4'h5, "R8 clear bit 0");
    apply(8'hFE, 8'h00, 4'hA, "R8 set bit 7");
    apply(8'hC5, 8'hFF, 4'h0, "R8 set already set");
    for (int i = 0; i < 8; i++) apply({2'b01, 3'd2, i[2:0]}, 8'h04, 4'h0, "R1 R9 index field");
    for (int i = 0; i < 3000; i++)
      apply(8'($urandom), 8'($urandom), 4'($urandom), "random");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule